// File: doc/BRIEF.md
# Bit-Programmable I/O Port with Read Polarity and Change Interrupt

This block is the register core of an eight-bit general-purpose I/O port. A serial front end, which is outside this block, turns bus transactions into single-cycle read and write strobes with a two-bit register address. The core keeps four registers:

- a captured input image
- an output latch
- a per-bit read polarity mask
- a per-bit direction mask

It drives a level and an enable for each pad. It also raises an interrupt when an input pin moves away from the image the master last read.

Pin levels arrive already sampled into the clock domain. Each pad enable comes from the direction mask. Each pad level comes from the output latch. A read of the input image stores the present pin levels. The master sees those levels, XOR-ed with the polarity mask, on the read data bus one cycle later. The interrupt is an open-drain pull-down enable, and it is active while a request is pending.

Top module: `gpio_pol_irq_port`

## Requirements
- R1: After reset, the output latch holds all ones, the polarity mask holds all zeros and the direction mask holds all ones. As a result `pin_oe` is 0, `pin_out` is all ones, `irq_od_en` is 0 and `reg_rdata` is 0.
- R2: Address 3 holds the direction mask, which can be written and read. Bit value 1 makes the pin an input with its driver off (`pin_oe` bit 0). Bit value 0 makes it an output (`pin_oe` bit 1). The change is visible on the cycle after the write.
- R3: Address 1 holds the output latch. After a write, `pin_out` carries the written value on the next cycle. A pin configured as an input keeps `pin_oe` at 0 whatever the latch holds.
- R4: A read of address 1 returns the stored latch value, never the pin levels.
- R5: A read of address 0 stores `pin_in` in the input image. On the next cycle `reg_rdata` shows `pin_in ^ polarity`. `reg_rdata` holds its value until the next read.
- R6: Address 2 holds the polarity mask. A write to it is returned unchanged by a read of address 2.
- R7: `irq_od_en` becomes 1 on the cycle after any input-configured pin differs from the stored input image. This includes the case where a pin is switched to input while it differs from the image.
- R8: `irq_od_en` returns to 0 on the cycle after a read of address 0. It also returns to 0 on the cycle after all input pins match the image again.
- R9: A difference on a pin configured as an output never raises `irq_od_en`.
- R10: A write to address 0 is ignored. It changes none of the other three registers, it does not update the stored image, and it does not clear a pending interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_addr | input | 2 | Register select: 0 input, 1 output, 2 polarity, 3 direction |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after a read strobe and held |
| pin_in | input | 8 | Sampled pad levels |
| pin_out | output | 8 | Pad drive levels |
| pin_oe | output | 8 | Pad drive enables, 1 drives |
| irq_od_en | output | 1 | Open-drain interrupt pull-down enable |

## Verification
The hardest situation to reach is an interrupt that stays pending while other bus traffic goes past. The interrupt must survive a write to the input address. It must also be silenced by a direction change that masks the differing bit, and then come back when the bit is unmasked again.

The bench walks each of the eight bits in turn from a different base pattern, in this order:

1. Arm the capture with a read, then flip one pin.
2. Flip the pin back, then flip it again.
3. Write to address 0 while the interrupt is pending.
4. Read to clear the interrupt.
5. Turn the bit into an output while its pin differs from the image.
6. Return the bit to input and check that the request comes back.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int unsigned REG_AW = 2;
    localparam logic [REG_AW-1:0] A_INPUT  = 2'd0;
    localparam logic [REG_AW-1:0] A_OUTPUT = 2'd1;
    localparam logic [REG_AW-1:0] A_POLAR  = 2'd2;
    localparam logic [REG_AW-1:0] A_DIRECT = 2'd3;
endpackage

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  latch_o,
    output logic [WIDTH-1:0]  polar_o,
    output logic [WIDTH-1:0]  direct_o,
    output logic [WIDTH-1:0]  direct_nxt_o
);
    typedef struct packed {
        logic [WIDTH-1:0] latch;
        logic [WIDTH-1:0] polar;
        logic [WIDTH-1:0] direct;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            case (wr_addr)
                A_OUTPUT: ctl_d.latch  = wr_data;
                A_POLAR:  ctl_d.polar  = wr_data;
                A_DIRECT: ctl_d.direct = wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.latch  <= '1;
            ctl_q.polar  <= '0;
            ctl_q.direct <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign latch_o      = ctl_q.latch;
    assign polar_o      = ctl_q.polar;
    assign direct_o     = ctl_q.direct;
    assign direct_nxt_o = ctl_d.direct;

    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_DIRECT) |=> (direct_o == $past(wr_data)));
    p_out_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_OUTPUT) |=> (latch_o == $past(wr_data)));
    p_pol_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_POLAR) |=> (polar_o == $past(wr_data)));
    p_in_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_addr == A_INPUT)
            |=> ($stable(latch_o) && $stable(polar_o) && $stable(direct_o)));
endmodule

// File: rtl/gpio_in_capture.sv
module gpio_in_capture
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] rd_addr,
    input  logic [WIDTH-1:0]  pin_in,
    input  logic [WIDTH-1:0]  latch,
    input  logic [WIDTH-1:0]  polar,
    input  logic [WIDTH-1:0]  direct,
    output logic [WIDTH-1:0]  image_nxt_o,
    output logic [WIDTH-1:0]  rdata_o
);
    typedef struct packed {
        logic [WIDTH-1:0] image;
        logic [WIDTH-1:0] rdata;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (rd_en) begin
            case (rd_addr)
                A_INPUT: begin
                    cap_d.image = pin_in;
                    cap_d.rdata = pin_in ^ polar;
                end
                A_OUTPUT: cap_d.rdata = latch;
                A_POLAR:  cap_d.rdata = polar;
                default:  cap_d.rdata = direct;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q.image <= pin_in;
            cap_q.rdata <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign image_nxt_o = cap_d.image;
    assign rdata_o     = cap_q.rdata;

    p_in_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == A_INPUT) |=> (rdata_o == ($past(pin_in) ^ $past(polar))));
    p_out_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == A_OUTPUT) |=> (rdata_o == $past(latch)));
    p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata_o));
endmodule

// File: rtl/gpio_change_irq.sv
module gpio_change_irq #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    input  logic [WIDTH-1:0] image_nxt,
    input  logic [WIDTH-1:0] direct_nxt,
    output logic             irq_o
);
    typedef struct packed {
        logic pend;
    } irq_t;

    irq_t irq_d, irq_q;
    logic [WIDTH-1:0] diff_in;

    for (genvar b = 0; b < WIDTH; b++) begin : g_diff
        assign diff_in[b] = (pin_in[b] != image_nxt[b]) && direct_nxt[b];
    end

    always_comb begin
        irq_d      = irq_q;
        irq_d.pend = |diff_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq_o = irq_q.pend;

    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(direct_nxt) != '0));
endmodule

// File: rtl/gpio_pol_irq_port.sv
module gpio_pol_irq_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WIDTH-1:0]  reg_wdata,
    output logic [WIDTH-1:0]  reg_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic              irq_od_en
);
    logic [WIDTH-1:0] latch_w, polar_w, direct_w, direct_nxt_w, image_nxt_w;

    gpio_ctrl_regs #(.WIDTH(WIDTH)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (reg_wr),
        .wr_addr      (reg_addr),
        .wr_data      (reg_wdata),
        .latch_o      (latch_w),
        .polar_o      (polar_w),
        .direct_o     (direct_w),
        .direct_nxt_o (direct_nxt_w)
    );

    gpio_in_capture #(.WIDTH(WIDTH)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (reg_rd),
        .rd_addr     (reg_addr),
        .pin_in      (pin_in),
        .latch       (latch_w),
        .polar       (polar_w),
        .direct      (direct_w),
        .image_nxt_o (image_nxt_w),
        .rdata_o     (reg_rdata)
    );

    gpio_change_irq #(.WIDTH(WIDTH)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_in     (pin_in),
        .image_nxt  (image_nxt_w),
        .direct_nxt (direct_nxt_w),
        .irq_o      (irq_od_en)
    );

    for (genvar b = 0; b < WIDTH; b++) begin : g_pad
        assign pin_oe[b]  = ~direct_w[b];
        assign pin_out[b] = latch_w[b];
    end

    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_INPUT) |=> !irq_od_en);
    p_outputs_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((&pin_oe) && !reg_wr) |=> !irq_od_en);
endmodule

// File: tb/gpio_pol_irq_port_tb_top.sv
module gpio_pol_irq_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0, pin_in = 8'd0;
    logic [7:0] reg_rdata, pin_out, pin_oe;
    logic       irq_od_en;
    int         total = 0, bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    gpio_pol_irq_port dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_od_en(irq_od_en)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    task automatic pins(input logic [7:0] v);
        @(negedge clk); pin_in = v;
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 oe", pin_oe, 8'h00);
        check("R1 out", pin_out, 8'hFF);
        check("R1 irq", {7'd0, irq_od_en}, 8'h00);
        check("R1 rdata", reg_rdata, 8'h00);
        rd(2'd2, v); check("R1 pol", v, 8'h00);
        rd(2'd3, v); check("R1 dir", v, 8'hFF);
        rd(2'd1, v); check("R1 latch", v, 8'hFF);

        // R2 direction sweep
        for (int c = 0; c < 256; c++) begin
            wr(2'd3, 8'(c));
            check("R2 oe", pin_oe, ~8'(c));
            if (c % 32 == 5) begin rd(2'd3, v); check("R2 readback", v, 8'(c)); end
        end
        // R3 R4 output latch sweep, pins opposite
        for (int o = 0; o < 256; o++) begin
            wr(2'd1, 8'(o));
            check("R3 pin_out", pin_out, 8'(o));
            pin_in = ~8'(o);
            rd(2'd1, v); check("R4 latch read", v, 8'(o));
        end
        wr(2'd3, 8'hFF);
        check("R3 inputs undriven", pin_oe, 8'h00);
        // R5 R6 polarity sweep
        for (int p = 0; p < 256; p++) begin
            wr(2'd2, 8'(p));
            @(negedge clk); pin_in = 8'(p * 37 + 11);
            rd(2'd0, v); check("R5 input read", v, 8'(p * 37 + 11) ^ 8'(p));
            repeat (2) @(negedge clk);
            check("R5 hold", reg_rdata, 8'(p * 37 + 11) ^ 8'(p));
            rd(2'd2, v); check("R6 pol read", v, 8'(p));
        end
        wr(2'd2, 8'h00);

        // R7 R8 R9 R10 per-bit interrupt walk
        for (int i = 0; i < 8; i++) begin
            logic [7:0] base, bitm;
            base = 8'(i * 29 + 3);
            bitm = 8'(1 << i);
            wr(2'd3, 8'hFF);
            pins(base);
            rd(2'd0, v);
            check("R8 idle after read", {7'd0, irq_od_en}, 8'h00);
            pins(base ^ bitm);
            check("R7 raise", {7'd0, irq_od_en}, 8'h01);
            pins(base);
            check("R8 return clears", {7'd0, irq_od_en}, 8'h00);
            pins(base ^ bitm);
            check("R7 raise again", {7'd0, irq_od_en}, 8'h01);
            wr(2'd0, 8'(~i));
            check("R10 irq kept", {7'd0, irq_od_en}, 8'h01);
            rd(2'd3, v); check("R10 dir kept", v, 8'hFF);
            rd(2'd2, v); check("R10 pol kept", v, 8'h00);
            rd(2'd1, v); check("R10 latch kept", v, 8'hFF);
            rd(2'd0, v); check("R5 read image", v, base ^ bitm);
            check("R8 read clears", {7'd0, irq_od_en}, 8'h00);
            wr(2'd3, ~bitm);
            pins(base);
            check("R9 output pin quiet", {7'd0, irq_od_en}, 8'h00);
            wr(2'd3, 8'hFF);
            check("R7 unmask raises", {7'd0, irq_od_en}, 8'h01);
            rd(2'd0, v);
            check("R8 final clear", {7'd0, irq_od_en}, 8'h00);
        end
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule